// File: doc/BRIEF.md
# Store Drain Chain (Three-Stage Write-Back Holding Path)

This block carries store operations from a pipelined integer unit to an external 32-bit bus. Each store passes through three holding registers in turn. The first register, on the integer-unit side, keeps the logical address, the data and the size. The second register, on the data-memory side, translates the logical address to a physical one and looks the physical address up in a small tag store. The third register, on the bus-controller side, keeps the physical address and the data steered onto its byte lanes. Only this third register drives the bus.

A parked store has lower priority than an operand read from the effective-address stage, so it can wait for as long as reads keep coming. A newer store from the execute stage pushes it onward. A store that hits the tag store goes out as a cache-update pulse and never reaches the bus. A store that fails alignment, translation or protection raises a fault pulse and is dropped. Every other store is written through to the bus under a request/acknowledge handshake.

Top module: `store_drain_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all three holding registers become empty. After reset `bus_req`, `cu_valid` and `fault_pulse` are 0 and `st_ready` is 1.
- R2: Stores that miss the tag store appear on the bus in the order in which they were accepted (`st_valid && st_ready` at a clock edge). None is lost or duplicated.
- R3: While `rd_req` is high and `st_valid` is low, a parked store stays in the first register and does not move toward the bus, for any number of cycles.
- R4: A store presented while `rd_req` is high forces the parked store into the second register in that same cycle, provided the second register is free. The new store is accepted in its place.
- R5: The bus address is `{logical_page + PAGE_BASE, page_offset}`, where the page offset is the low `PAGE_BITS` bits of the logical address and the logical page is the bits above them.
- R6: Size codes are 0 for byte, 1 for 16-bit word and 2 for 32-bit long. Byte lane k is data bits [8k+7:8k] and is selected by `bus_be[k]`. Lane k is used for address offset k (address bits [1:0]). A byte uses the one lane at its offset. A word uses lanes 1:0 at offset 0 or lanes 3:2 at offset 2. A long uses all four lanes. The source data sits in the low bits of `st_data`, and lanes the store does not use read as zero.
- R7: A word at an odd offset, a long at a nonzero offset, or size code 3 gives a one-cycle `fault_pulse` with `fault_cause` = 3. The store is dropped.
- R8: A logical page at or above `NUM_PAGES` faults with cause 1. A page whose bit in `RO_MASK` is set faults with cause 2. Both kinds of store are dropped, and later stores still drain.
- R9: A store whose physical address matches a line loaded through `fill_valid`/`fill_paddr` gives a one-cycle `cu_valid` pulse carrying the physical address, the steered data and the byte enables, and is not sent to the bus. The tag store is direct-mapped and indexed by the physical address bits just above the line offset.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_addr`, `bus_data` and `bus_be` hold their values. The third register clears at the edge where `bus_ack` is sampled high.
- R11: When the first register is occupied and cannot drain, `st_ready` is low and the pending store in the first register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Execute stage offers a store |
| st_ready | output | 1 | First holding register can take the store |
| st_addr | input | AW | Logical address of the store |
| st_data | input | 32 | Store data, right-aligned |
| st_size | input | 2 | 0 byte, 1 word, 2 long |
| rd_req | input | 1 | Operand read request from the effective-address stage |
| fill_valid | input | 1 | Load one line into the tag store |
| fill_paddr | input | AW | Physical address of the line being loaded |
| cu_valid | output | 1 | Cache-update pulse for a store hit |
| cu_addr | output | AW | Physical address of the hit |
| cu_data | output | 32 | Lane-steered data of the hit |
| cu_be | output | 4 | Byte enables of the hit |
| fault_pulse | output | 1 | One-cycle fault indication; the store was dropped |
| fault_cause | output | 2 | 1 translation miss, 2 protection, 3 misalignment |
| bus_req | output | 1 | Third holding register holds a write |
| bus_addr | output | AW | Physical write address |
| bus_data | output | 32 | Lane-steered write data |
| bus_be | output | 4 | Active-high byte enables |
| bus_ack | input | 1 | Bus has taken the write |

## Verification
A wrong valid bit in any holding register shows up at the ports within a few cycles. It appears as a missing, repeated or reordered bus write once the chain drains, or as `st_ready` staying low when nothing is in flight. A priority error shows as a bus write appearing while `rd_req` holds a parked store, or as a forced store that never arrives. Errors in translation, lane steering or tag matching change the address, data or byte enables of the very next write or cache-update pulse. The bench compares these values directly against values it computes from the address map and size encoding. A handshake error shows as bus fields that change before acknowledge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_XMISS = 2'd1,
    FC_PROT  = 2'd2,
    FC_ALIGN = 2'd3
  } cause_e;
endpackage

// File: rtl/sdc_xlate.sv
module sdc_xlate #(
  parameter int AW = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 16,
  parameter int PAGE_BASE = 128,
  parameter logic [NUM_PAGES-1:0] RO_MASK = 16'h8000
) (
  input  logic [AW-1:0] laddr,
  output logic [AW-1:0] paddr,
  output logic          miss,
  output logic          prot
);
  localparam int PPW = AW - PAGE_BITS;
  localparam int PIW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  logic [PPW-1:0] ppage_tab [NUM_PAGES];
  logic [NUM_PAGES-1:0] ro_tab;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_tab
    assign ppage_tab[g] = PPW'(g + PAGE_BASE);
    assign ro_tab[g]    = RO_MASK[g];
  end

  logic [PPW-1:0] lpage;
  logic [PIW-1:0] idx;
  logic           in_range;

  assign lpage    = laddr[AW-1:PAGE_BITS];
  assign idx      = lpage[PIW-1:0];
  assign in_range = lpage < PPW'(NUM_PAGES);
  assign miss     = !in_range;
  assign prot     = in_range && ro_tab[idx];
  assign paddr    = {ppage_tab[idx], laddr[PAGE_BITS-1:0]};
endmodule

// File: rtl/sdc_tags.sv
module sdc_tags #(
  parameter int AW = 32,
  parameter int SETS = 8,
  parameter int LINE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_paddr,
  input  logic [AW-1:0] look_paddr,
  output logic          hit
);
  localparam int IW = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TW = AW - LINE_BITS - IW;

  logic [SETS-1:0] vld;
  logic [TW-1:0]   tag_mem [SETS];
  logic [IW-1:0]   fidx, lidx;
  logic [TW-1:0]   ftag, ltag;
  logic            unused_low;

  assign fidx = fill_paddr[LINE_BITS +: IW];
  assign ftag = fill_paddr[AW-1 -: TW];
  assign lidx = look_paddr[LINE_BITS +: IW];
  assign ltag = look_paddr[AW-1 -: TW];
  assign unused_low = ^{fill_paddr[LINE_BITS-1:0], look_paddr[LINE_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (fill_valid) vld[fidx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_valid) tag_mem[fidx] <= ftag;
  end

  assign hit = vld[lidx] && (tag_mem[lidx] == ltag);
endmodule

// File: rtl/sdc_lanes.sv
module sdc_lanes
  import sdc_pkg::*;
(
  input  logic [1:0]    size,
  input  logic [1:0]    off,
  input  logic [DW-1:0] din,
  output logic [NB-1:0] be,
  output logic [DW-1:0] dout,
  output logic          misalign
);
  logic [4:0] sh;
  assign sh = {off, 3'b000};

  always_comb begin
    misalign = 1'b0;
    be       = '0;
    dout     = '0;
    case (size_e'(size))
      SZ_BYTE: begin
        be   = NB'(1) << off;
        dout = {{(DW-8){1'b0}}, din[7:0]} << sh;
      end
      SZ_WORD: begin
        misalign = off[0];
        be       = NB'(3) << off;
        dout     = {{(DW-16){1'b0}}, din[15:0]} << sh;
      end
      SZ_LONG: begin
        misalign = |off;
        be       = '1;
        dout     = din;
      end
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/store_drain_chain.sv
module store_drain_chain
  import sdc_pkg::*;
#(
  parameter int AW = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 16,
  parameter int PAGE_BASE = 128,
  parameter logic [NUM_PAGES-1:0] RO_MASK = 16'h8000,
  parameter int SETS = 8,
  parameter int LINE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [1:0]    st_size,
  input  logic          rd_req,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_paddr,
  output logic          cu_valid,
  output logic [AW-1:0] cu_addr,
  output logic [DW-1:0] cu_data,
  output logic [NB-1:0] cu_be,
  output logic          fault_pulse,
  output logic [1:0]    fault_cause,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic [NB-1:0] bus_be,
  input  logic          bus_ack
);
  // Stage 1: logical holding register (integer-unit side)
  logic          s1_v;
  logic [AW-1:0] s1_a;
  logic [DW-1:0] s1_d;
  logic [1:0]    s1_sz;
  // Stage 2: data-memory-side holding register
  logic          s2_v;
  logic [AW-1:0] s2_a;
  logic [DW-1:0] s2_d;
  logic [1:0]    s2_sz;
  // Stage 3: bus-side holding register
  logic          s3_v;

  logic [AW-1:0] s2_pa;
  logic          s2_xmiss, s2_prot, s2_mis, s2_tag_hit;
  logic [NB-1:0] s2_be;
  logic [DW-1:0] s2_ld;
  logic          s2_fault, s2_hit, s3_free, s2_adv, s2_free, s1_adv;
  logic [1:0]    s2_cause;

  sdc_xlate #(
    .AW(AW), .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES),
    .PAGE_BASE(PAGE_BASE), .RO_MASK(RO_MASK)
  ) u_xlate (
    .laddr(s2_a), .paddr(s2_pa), .miss(s2_xmiss), .prot(s2_prot)
  );

  sdc_tags #(.AW(AW), .SETS(SETS), .LINE_BITS(LINE_BITS)) u_tags (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_paddr(fill_paddr),
    .look_paddr(s2_pa), .hit(s2_tag_hit)
  );

  sdc_lanes u_lanes (
    .size(s2_sz), .off(s2_a[1:0]), .din(s2_d),
    .be(s2_be), .dout(s2_ld), .misalign(s2_mis)
  );

  always_comb begin
    s2_cause = FC_NONE;
    if (s2_mis)        s2_cause = FC_ALIGN;
    else if (s2_xmiss) s2_cause = FC_XMISS;
    else if (s2_prot)  s2_cause = FC_PROT;
  end

  assign s2_fault = s2_mis || s2_xmiss || s2_prot;
  assign s2_hit   = !s2_fault && s2_tag_hit;
  assign s3_free  = !s3_v || bus_ack;
  assign s2_adv   = s2_v && (s2_fault || s2_hit || s3_free);
  assign s2_free  = !s2_v || s2_adv;
  // operand read wins the port unless a newer store forces the parked one out
  assign s1_adv   = s1_v && s2_free && (!rd_req || st_valid);
  assign st_ready = !s1_v || s1_adv;
  assign bus_req  = s3_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v        <= 1'b0;
      s2_v        <= 1'b0;
      s3_v        <= 1'b0;
      cu_valid    <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      if (st_valid && st_ready) s1_v <= 1'b1;
      else if (s1_adv)          s1_v <= 1'b0;
      if (s1_adv)               s2_v <= 1'b1;
      else if (s2_adv)          s2_v <= 1'b0;
      if (s2_adv && !s2_fault && !s2_hit) s3_v <= 1'b1;
      else if (bus_ack)                   s3_v <= 1'b0;
      cu_valid    <= s2_adv && s2_hit;
      fault_pulse <= s2_adv && s2_fault;
    end
  end

  always_ff @(posedge clk) begin
    if (st_valid && st_ready) begin
      s1_a  <= st_addr;
      s1_d  <= st_data;
      s1_sz <= st_size;
    end
    if (s1_adv) begin
      s2_a  <= s1_a;
      s2_d  <= s1_d;
      s2_sz <= s1_sz;
    end
    if (s2_adv && !s2_fault && !s2_hit) begin
      bus_addr <= s2_pa;
      bus_data <= s2_ld;
      bus_be   <= s2_be;
    end
    if (s2_adv && s2_hit) begin
      cu_addr <= s2_pa;
      cu_data <= s2_ld;
      cu_be   <= s2_be;
    end
    if (s2_adv && s2_fault) fault_cause <= s2_cause;
  end

  assert_park_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_v && rd_req && !st_valid) |=> (s1_v && $stable(s1_a)));

  assert_force_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_v && rd_req && st_valid && s2_free) |=> (s2_v && s2_a == $past(s1_a)));

  assert_offset_R5: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> (s2_pa[PAGE_BITS-1:0] == s2_a[PAGE_BITS-1:0]));

  assert_be_count_R6: assert property (@(posedge clk) disable iff (rst)
    (s2_v && !s2_fault) |-> ($countones(s2_be) == (1 << s2_sz)));

  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> !cu_valid);

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_data) && $stable(bus_be)));

  assert_no_loss_R11: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> (s1_v && $stable(s1_a)));
endmodule

// File: tb/store_drain_chain_test.sv
module store_drain_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [1:0]  st_size = '0;
  logic        rd_req = 1'b0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_paddr = '0;
  logic        cu_valid;
  logic [31:0] cu_addr;
  logic [31:0] cu_data;
  logic [3:0]  cu_be;
  logic        fault_pulse;
  logic [1:0]  fault_cause;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic [31:0] bus_data;
  logic [3:0]  bus_be;
  logic        bus_ack = 1'b0;

  store_drain_chain uut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_size(st_size), .rd_req(rd_req),
    .fill_valid(fill_valid), .fill_paddr(fill_paddr),
    .cu_valid(cu_valid), .cu_addr(cu_addr), .cu_data(cu_data), .cu_be(cu_be),
    .fault_pulse(fault_pulse), .fault_cause(fault_cause),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be),
    .bus_ack(bus_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stalls = 0;
  int ack_lat = 0;
  int wcnt = 0;

  logic [31:0] rec_a [64];
  logic [31:0] rec_d [64];
  logic [3:0]  rec_b [64];
  int nbus = 0;
  logic [31:0] exp_a [64];
  logic [31:0] exp_d [64];
  logic [3:0]  exp_b [64];
  int nexp = 0;
  logic [31:0] cu_ra, cu_rd;
  logic [3:0]  cu_rb;
  int ncu = 0;
  logic [1:0]  f_cause [16];
  int nflt = 0;
  logic [31:0] snap_a, snap_d;
  logic [3:0]  snap_b;
  bit          held_ok;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // bus model and monitor, all at the falling edge
  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (!rst) begin
      if (cu_valid) begin
        cu_ra = cu_addr; cu_rd = cu_data; cu_rb = cu_be; ncu++;
      end
      if (fault_pulse) begin
        f_cause[nflt % 16] = fault_cause; nflt++;
      end
      if (bus_req) begin
        if (wcnt == 0) begin
          snap_a = bus_addr; snap_d = bus_data; snap_b = bus_be; held_ok = 1'b1;
        end else if (bus_addr != snap_a || bus_data != snap_d || bus_be != snap_b) begin
          held_ok = 1'b0;
        end
        if (wcnt >= ack_lat) begin
          bus_ack = 1'b1;
          chk(held_ok, "R10 bus fields held until ack", {31'b0, held_ok}, 64'd1);
          rec_a[nbus % 64] = bus_addr; rec_d[nbus % 64] = bus_data; rec_b[nbus % 64] = bus_be;
          nbus++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [3:0] e_be(input logic [1:0] sz, input logic [31:0] a);
    case (sz)
      2'd0: case (a[1:0]) 2'd0: e_be = 4'b0001; 2'd1: e_be = 4'b0010;
                          2'd2: e_be = 4'b0100; default: e_be = 4'b1000; endcase
      2'd1: e_be = a[1] ? 4'b1100 : 4'b0011;
      default: e_be = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] e_dat(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    logic [3:0]  b;
    logic [31:0] m;
    b = e_be(sz, a);
    m = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    case (sz)
      2'd0: e_dat = {4{d[7:0]}} & m;
      2'd1: e_dat = {2{d[15:0]}} & m;
      default: e_dat = d;
    endcase
  endfunction

  function automatic logic [31:0] e_pa(input logic [31:0] a);
    e_pa = (((a >> 12) + 32'd128) << 12) | (a & 32'hFFF);
  endfunction

  task automatic expect_bus(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz);
    exp_a[nexp % 64] = e_pa(a);
    exp_d[nexp % 64] = e_dat(sz, a, d);
    exp_b[nexp % 64] = e_be(sz, a);
    nexp++;
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz);
    st_valid = 1'b1; st_addr = a; st_data = d; st_size = sz;
    #1;
    while (!st_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic verify_bus(input int from, input string tag);
    chk(nbus == nexp, {tag, " bus write count"}, 64'(nbus), 64'(nexp));
    for (int i = from; i < nexp && i < nbus; i++) begin
      chk(rec_a[i % 64] == exp_a[i % 64], {tag, " R5 address"}, 64'(rec_a[i % 64]), 64'(exp_a[i % 64]));
      chk(rec_d[i % 64] == exp_d[i % 64], {tag, " R6 lane data"}, 64'(rec_d[i % 64]), 64'(exp_d[i % 64]));
      chk(rec_b[i % 64] == exp_b[i % 64], {tag, " R6 byte enables"}, 64'(rec_b[i % 64]), 64'(exp_b[i % 64]));
    end
  endtask

  task automatic t_reset();
    chk(bus_req == 1'b0, "R1 bus_req after reset", 64'(bus_req), 64'd0);
    chk(st_ready == 1'b1, "R1 st_ready after reset", 64'(st_ready), 64'd1);
    chk(cu_valid == 1'b0 && fault_pulse == 1'b0, "R1 pulses idle after reset",
        64'({cu_valid, fault_pulse}), 64'd0);
  endtask

  task automatic t_order();
    int base;
    base = nexp;
    ack_lat = 0;
    send(32'h0000_1004, 32'h1122_3344, 2'd2); expect_bus(32'h0000_1004, 32'h1122_3344, 2'd2);
    send(32'h0000_2002, 32'h0000_BEEF, 2'd1); expect_bus(32'h0000_2002, 32'h0000_BEEF, 2'd1);
    send(32'h0000_5003, 32'h0000_00A5, 2'd0); expect_bus(32'h0000_5003, 32'h0000_00A5, 2'd0);
    send(32'h0000_7001, 32'h0000_005A, 2'd0); expect_bus(32'h0000_7001, 32'h0000_005A, 2'd0);
    send(32'h0000_E000, 32'h0000_1234, 2'd1); expect_bus(32'h0000_E000, 32'h0000_1234, 2'd1);
    repeat (10) @(negedge clk);
    verify_bus(base, "R2 order");
  endtask

  task automatic t_prio();
    int base;
    base = nbus;
    ack_lat = 0;
    rd_req = 1'b1;
    send(32'h0000_1100, 32'hAAAA_0001, 2'd2);
    repeat (10) @(negedge clk);
    chk(nbus == base && !bus_req, "R3 parked store held by reads", 64'(nbus - base), 64'd0);
    send(32'h0000_2200, 32'hBBBB_0002, 2'd2);
    expect_bus(32'h0000_1100, 32'hAAAA_0001, 2'd2);
    repeat (6) @(negedge clk);
    chk(nbus == base + 1, "R4 forced store reached bus", 64'(nbus - base), 64'd1);
    chk(rec_a[base % 64] == e_pa(32'h0000_1100), "R4 forced store address",
        64'(rec_a[base % 64]), 64'(e_pa(32'h0000_1100)));
    repeat (6) @(negedge clk);
    chk(nbus == base + 1, "R3 second store parked", 64'(nbus - base), 64'd1);
    rd_req = 1'b0;
    expect_bus(32'h0000_2200, 32'hBBBB_0002, 2'd2);
    repeat (8) @(negedge clk);
    verify_bus(base, "R4 release");
  endtask

  task automatic t_fault();
    int b0, f0;
    b0 = nbus; f0 = nflt;
    ack_lat = 0;
    send(32'h0000_1002, 32'h0102_0304, 2'd2);
    repeat (4) @(negedge clk);
    send(32'h0000_1001, 32'h0000_0506, 2'd1);
    repeat (4) @(negedge clk);
    send(32'h0001_4000, 32'h0000_0077, 2'd0);
    repeat (4) @(negedge clk);
    send(32'h0000_F010, 32'h0000_0088, 2'd0);
    repeat (6) @(negedge clk);
    chk(nflt == f0 + 4, "R7 R8 fault pulse count", 64'(nflt - f0), 64'd4);
    chk(f_cause[f0 % 16] == 2'd3, "R7 long misaligned cause", 64'(f_cause[f0 % 16]), 64'd3);
    chk(f_cause[(f0 + 1) % 16] == 2'd3, "R7 word odd cause", 64'(f_cause[(f0 + 1) % 16]), 64'd3);
    chk(f_cause[(f0 + 2) % 16] == 2'd1, "R8 translation miss cause", 64'(f_cause[(f0 + 2) % 16]), 64'd1);
    chk(f_cause[(f0 + 3) % 16] == 2'd2, "R8 protection cause", 64'(f_cause[(f0 + 3) % 16]), 64'd2);
    chk(nbus == b0, "R7 R8 faulting stores dropped", 64'(nbus - b0), 64'd0);
    send(32'h0000_3006, 32'h0000_C0DE, 2'd1); expect_bus(32'h0000_3006, 32'h0000_C0DE, 2'd1);
    repeat (6) @(negedge clk);
    verify_bus(b0, "R8 drain after faults");
  endtask

  task automatic t_hit();
    int b0, c0;
    b0 = nbus; c0 = ncu;
    ack_lat = 0;
    fill_valid = 1'b1; fill_paddr = 32'h0008_3040;
    @(negedge clk);
    fill_valid = 1'b0;
    send(32'h0000_3040, 32'hCAFE_F00D, 2'd2);
    repeat (6) @(negedge clk);
    chk(ncu == c0 + 1, "R9 cache update pulse", 64'(ncu - c0), 64'd1);
    chk(cu_ra == 32'h0008_3040, "R9 cache update address", 64'(cu_ra), 64'h83040);
    chk(cu_rd == 32'hCAFE_F00D && cu_rb == 4'hF, "R9 cache update data/be",
        64'({cu_rb, cu_rd}), 64'({4'hF, 32'hCAFE_F00D}));
    chk(nbus == b0, "R9 hit kept off bus", 64'(nbus - b0), 64'd0);
    send(32'h0000_3050, 32'h0000_0011, 2'd0); expect_bus(32'h0000_3050, 32'h0000_0011, 2'd0);
    send(32'h0000_4040, 32'h0000_0022, 2'd0); expect_bus(32'h0000_4040, 32'h0000_0022, 2'd0);
    repeat (8) @(negedge clk);
    chk(ncu == c0 + 1, "R9 misses give no update", 64'(ncu - c0), 64'd1);
    verify_bus(b0, "R9 misses written through");
  endtask

  task automatic t_handshake();
    int b0;
    b0 = nbus;
    ack_lat = 6;
    send(32'h0000_6008, 32'h5566_7788, 2'd2); expect_bus(32'h0000_6008, 32'h5566_7788, 2'd2);
    while (nbus == b0) @(negedge clk);
    @(negedge clk);
    chk(bus_req == 1'b0, "R10 request clears after ack", 64'(bus_req), 64'd0);
    verify_bus(b0, "R10 slow bus");
  endtask

  task automatic t_backpressure();
    int b0;
    b0 = nbus;
    stalls = 0;
    ack_lat = 15;
    for (int i = 0; i < 5; i++) begin
      send(32'h0000_2000 + 32'(i * 16), 32'h0100_0000 + 32'(i), 2'd2);
      expect_bus(32'h0000_2000 + 32'(i * 16), 32'h0100_0000 + 32'(i), 2'd2);
    end
    chk(stalls > 0, "R11 st_ready low under backpressure", 64'(stalls), 64'd1);
    repeat (120) @(negedge clk);
    verify_bus(b0, "R11 no store lost");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_prio();
    t_fault();
    t_hit();
    t_handshake();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule